// File: doc/BRIEF.md
# Multiplexed Bus Address Latch and Device Select

This block is the glue between an 8-bit microcontroller with a shared address/data bus and four external devices: a 32K by 8 RAM, a character LCD and two analog-to-digital converters. During the address phase of an external cycle the controller drives the low address byte on the shared port and raises the latch strobe. The block passes that byte through while the strobe is high and keeps it once the strobe drops. The kept byte is joined with the high address byte, which the controller holds on a dedicated port, into a 16-bit address.

From the 16-bit address the block builds four active-low device enables. It decodes only three address bits: bit 15, bit 6 and bit 5. Each device therefore answers at many aliased addresses, and no address selects two devices. The RAM enable follows bit 15 alone, because the RAM takes its own read and write strobes. The three I/O enables are also gated by the active-low read strobe, so each of them asserts only while a read of its region is in progress.

Top module: `bus_glue`

## Requirements
- R1: While `ale` is high, `addr[7:0]` equals `ad_lo` in the same cycle, with no clock edge needed.
- R2: After `ale` falls, `addr[7:0]` keeps the value `ad_lo` had at the last rising clock edge with `ale` high, whatever `ad_lo` does afterwards.
- R3: `addr[15:8]` always equals `a_hi`.
- R4: `ram_ce_n` is low exactly when address bit 15 is 1. It does not depend on `rd_n`.
- R5: `lcd_ce_n` is low exactly when bit 15 = 0, bit 6 = 0, bit 5 = 0 and `rd_n` = 0. This region includes addresses 0 to 31.
- R6: `adc1_ce_n` is low exactly when bit 15 = 0, bit 6 = 0, bit 5 = 1 and `rd_n` = 0. This region includes address 32.
- R7: `adc2_ce_n` is low exactly when bit 15 = 0, bit 6 = 1, bit 5 = 0 and `rd_n` = 0. This region includes address 64.
- R8: With bit 15 = 0, bit 6 = 1 and bit 5 = 1, all four enables stay high. With `rd_n` high, all three I/O enables stay high.
- R9: For any address and any `rd_n`, at most one of the four enables is low.
- R10: While `rst_n` is low, the held low byte is cleared, so with `ale` low `addr[7:0]` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address latch strobe, high during the address phase |
| ad_lo | input | 8 | Shared port carrying the low address byte, then data |
| a_hi | input | 8 | High address byte |
| rd_n | input | 1 | Active-low read strobe |
| addr | output | 16 | Assembled address; LCD uses bits 4:0 |
| ram_ce_n | output | 1 | RAM enable, active low |
| lcd_ce_n | output | 1 | LCD enable, active low |
| adc1_ce_n | output | 1 | First ADC enable, active low |
| adc2_ce_n | output | 1 | Second ADC enable, active low |

## Verification
In one cycle the latch strobe falls, the shared port changes from address to data, and the read strobe then asserts. The enables must decode the held byte, not the data now on the port. The bench runs this seven-cycle read order for each device region and puts conflicting data on the port after the strobe falls. The enable pattern must match a decode of the latched address and ignore the data byte. A full sweep of all 65536 addresses with the read strobe in both states checks the decode and the at-most-one-enable rule at every address.

// File: rtl/bus_glue_pkg.sv
package bus_glue_pkg;
  // I/O region codes formed from {hi select bit, lo select bit}
  localparam int unsigned NUM_IO = 3;
  localparam logic [1:0] IO_CODE_LCD  = 2'b00;
  localparam logic [1:0] IO_CODE_ADC1 = 2'b01;
  localparam logic [1:0] IO_CODE_ADC2 = 2'b10;

  function automatic logic [1:0] io_code(input int unsigned idx);
    case (idx)
      0:       return IO_CODE_LCD;
      1:       return IO_CODE_ADC1;
      default: return IO_CODE_ADC2;
    endcase
  endfunction
endpackage

// File: rtl/glue_addr_latch.sv
module glue_addr_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held_q;
  logic [W-1:0] held_d;

  // next-state: load while strobe high, else keep
  always_comb begin
    held_d = held_q;
    if (le) held_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  // transparent path while strobe high
  assign q = le ? d : held_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !le |=> (le || $stable(q)))
    else $error("R2: latched byte moved while strobe low");
endmodule

// File: rtl/glue_decode.sv
module glue_decode
  import bus_glue_pkg::*;
#(
  parameter int unsigned N_IO = NUM_IO
) (
  input  logic            a_top,
  input  logic            a_hsel,
  input  logic            a_lsel,
  output logic            ram_sel,
  output logic [N_IO-1:0] io_sel
);
  logic [1:0] code;
  assign code    = {a_hsel, a_lsel};
  assign ram_sel = a_top;

  for (genvar i = 0; i < N_IO; i++) begin : g_io
    localparam logic [1:0] CODE = io_code(i);
    assign io_sel[i] = !a_top && (code == CODE);
  end
endmodule

// File: rtl/glue_qualify.sv
module glue_qualify #(
  parameter int unsigned N_IO = 3
) (
  input  logic            ram_sel,
  input  logic [N_IO-1:0] io_sel,
  input  logic            rd_n,
  output logic            ram_ce_n,
  output logic [N_IO-1:0] io_ce_n
);
  assign ram_ce_n = ~ram_sel;

  for (genvar i = 0; i < N_IO; i++) begin : g_q
    assign io_ce_n[i] = ~io_sel[i] | rd_n;
  end

  always_comb begin
    assert_io_idle_R8: assert (!rd_n || (&io_ce_n))
      else $error("R8: I/O enable low without read");
  end
endmodule

// File: rtl/bus_glue.sv
module bus_glue
  import bus_glue_pkg::*;
#(
  parameter int unsigned LO_W     = 8,
  parameter int unsigned HI_W     = 8,
  parameter int unsigned TOP_BIT  = 15,
  parameter int unsigned HSEL_BIT = 6,
  parameter int unsigned LSEL_BIT = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ale,
  input  logic [LO_W-1:0]      ad_lo,
  input  logic [HI_W-1:0]      a_hi,
  input  logic                 rd_n,
  output logic [LO_W+HI_W-1:0] addr,
  output logic                 ram_ce_n,
  output logic                 lcd_ce_n,
  output logic                 adc1_ce_n,
  output logic                 adc2_ce_n
);
  localparam int unsigned AW = LO_W + HI_W;

  logic [LO_W-1:0] lo_byte;
  logic            ram_sel;
  logic [NUM_IO-1:0] io_sel;
  logic [NUM_IO-1:0] io_ce_n;

  glue_addr_latch #(.W(LO_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .le(ale), .d(ad_lo), .q(lo_byte)
  );

  assign addr = {a_hi, lo_byte};

  glue_decode #(.N_IO(NUM_IO)) u_dec (
    .a_top(addr[TOP_BIT]), .a_hsel(addr[HSEL_BIT]), .a_lsel(addr[LSEL_BIT]),
    .ram_sel(ram_sel), .io_sel(io_sel)
  );

  glue_qualify #(.N_IO(NUM_IO)) u_qual (
    .ram_sel(ram_sel), .io_sel(io_sel), .rd_n(rd_n),
    .ram_ce_n(ram_ce_n), .io_ce_n(io_ce_n)
  );

  assign lcd_ce_n  = io_ce_n[0];
  assign adc1_ce_n = io_ce_n[1];
  assign adc2_ce_n = io_ce_n[2];

  assert_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (addr[LO_W-1:0] == ad_lo))
    else $error("R1: low byte not transparent");

  assert_ram_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ce_n != addr[TOP_BIT])
    else $error("R4: RAM enable disagrees with top bit");

  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~ram_ce_n, ~lcd_ce_n, ~adc1_ce_n, ~adc2_ce_n}) <= 1)
    else $error("R9: two enables low");

  assert_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr[AW-1:LO_W] == a_hi)
    else $error("R3: high byte mismatch");
endmodule

// File: tb/sim_bus_glue.sv
module sim_bus_glue;
  localparam int PERIOD = 10;

  logic clk, rst_n, ale, rd_n;
  logic [7:0] ad_lo, a_hi;
  logic [15:0] addr;
  logic ram_ce_n, lcd_ce_n, adc1_ce_n, adc2_ce_n;

  int checks = 0;
  int fails  = 0;

  bus_glue u0 (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_lo(ad_lo), .a_hi(a_hi),
    .rd_n(rd_n), .addr(addr), .ram_ce_n(ram_ce_n), .lcd_ce_n(lcd_ce_n),
    .adc1_ce_n(adc1_ce_n), .adc2_ce_n(adc2_ce_n)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // enables packed {ram, lcd, adc1, adc2}, active low
  function automatic logic [3:0] ref_ce(input logic [15:0] a, input logic r_n);
    logic [3:0] e;
    e = 4'b1111;
    if (a[15]) e[3] = 1'b0;
    else if (!r_n) begin
      case ({a[6], a[5]})
        2'b00: e[2] = 1'b0;
        2'b01: e[1] = 1'b0;
        2'b10: e[0] = 1'b0;
        default: ;
      endcase
    end
    return e;
  endfunction

  function automatic logic [3:0] got_ce();
    return {ram_ce_n, lcd_ce_n, adc1_ce_n, adc2_ce_n};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // vector: {a_hi, lo, rd_n, expected enables}
  typedef struct packed { logic [7:0] hi; logic [7:0] lo; logic rn; logic [3:0] ce; } vec_t;
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{8'h80, 8'h00, 1'b0, 4'b0111},  // R4 RAM base
    '{8'hFF, 8'hFF, 1'b1, 4'b0111},  // R4 RAM, no read
    '{8'h00, 8'h00, 1'b0, 4'b1011},  // R5 LCD addr 0
    '{8'h00, 8'h1F, 1'b0, 4'b1011},  // R5 LCD addr 31
    '{8'h12, 8'h85, 1'b0, 4'b1011},  // R5 LCD alias
    '{8'h00, 8'h20, 1'b0, 4'b1101},  // R6 ADC1 addr 32
    '{8'h7F, 8'h3F, 1'b0, 4'b1101},  // R6 ADC1 alias
    '{8'h00, 8'h40, 1'b0, 4'b1110},  // R7 ADC2 addr 64
    '{8'h55, 8'hDF, 1'b0, 4'b1110},  // R7 ADC2 alias
    '{8'h00, 8'h60, 1'b0, 4'b1111},  // R8 empty region
    '{8'h00, 8'h20, 1'b1, 4'b1111},  // R8 no read
    '{8'h00, 8'h00, 1'b1, 4'b1111}   // R8 no read LCD
  };

  // 7-cycle external read: address phase, latch fall, read strobe
  task automatic read_cycle(input logic [15:0] a, input logic [7:0] junk, input string req);
    @(negedge clk); ale = 1'b1; a_hi = a[15:8]; ad_lo = a[7:0]; rd_n = 1'b1;
    @(negedge clk); ale = 1'b0; ad_lo = junk;
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    check({req, " read"}, {28'd0, got_ce()}, {28'd0, ref_ce(a, 1'b0)});
    check("R2 held", {16'd0, addr}, {16'd0, a});
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk); #1;
    check({req, " idle"}, {28'd0, got_ce()}, {28'd0, ref_ce(a, 1'b1)});
  endtask

  initial begin
    #(PERIOD*200000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ale = 1'b0; rd_n = 1'b1; ad_lo = 8'hA5; a_hi = 8'h00;
    repeat (3) @(negedge clk);
    #1 check("R10 reset low byte", {24'd0, addr[7:0]}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // table walk, strobe high (transparent)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ale = 1'b1; a_hi = VEC[i].hi; ad_lo = VEC[i].lo; rd_n = VEC[i].rn;
      #1;
      check("R4-R8 table", {28'd0, got_ce()}, {28'd0, VEC[i].ce});
      check("R1 pass", {24'd0, addr[7:0]}, {24'd0, VEC[i].lo});
      check("R3 high", {24'd0, addr[15:8]}, {24'd0, VEC[i].hi});
    end

    // R2: hold after strobe fall
    @(negedge clk); ale = 1'b1; ad_lo = 8'h3C;
    @(negedge clk); ale = 1'b0; ad_lo = 8'hC3;
    #1 check("R2 hold", {24'd0, addr[7:0]}, 32'h3C);
    @(negedge clk); ad_lo = 8'h99;
    #1 check("R2 hold later", {24'd0, addr[7:0]}, 32'h3C);

    // read cycles with conflicting data after latch fall
    read_cycle(16'h0005, 8'h40, "R5");
    read_cycle(16'h0020, 8'h00, "R6");
    read_cycle(16'h0040, 8'h20, "R7");
    read_cycle(16'h0060, 8'h00, "R8");
    read_cycle(16'h8123, 8'h00, "R4");

    // full sweep, both read states
    @(negedge clk); ale = 1'b1;
    for (int a = 0; a < 65536; a++) begin
      for (int r = 0; r < 2; r++) begin
        a_hi = a[15:8]; ad_lo = a[7:0]; rd_n = r[0];
        #1;
        check("R9 sweep decode", {28'd0, got_ce()}, {28'd0, ref_ce(a[15:0], r[0])});
        check("R9 at most one", $countones(~got_ce()) <= 1, 32'd1);
      end
    end

    // R10 again: reset mid-run clears held byte
    @(negedge clk); ale = 1'b0; rst_n = 1'b0;
    #1 check("R10 reset mid-run", {24'd0, addr[7:0]}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule